// File: doc/BRIEF.md
# Sound level interrupt monitor

This block sits beside a sound level meter and watches each new 8-bit level sample. It drives an active-low, open-drain style interrupt request towards a host. The request can come from one of two sources, selected by a mode input. In window mode, a sample that lies outside a low/high threshold pair raises it. In fill mode, a history buffer that holds 90 or more readings raises it.

Once raised, the request stays latched until the host sends a clear pulse. In fill mode the host has to empty the history before it clears, because a fill count that is still at the limit raises the request again at once.

Alongside the interrupt, the block keeps the smallest and the largest sample seen since reset, or since the last min/max clear pulse. A two-state machine (`ST_IDLE`, `ST_PEND`) holds the latch:

- `ST_IDLE` to `ST_PEND` ("arm") when an enabled trigger is seen.
- `ST_PEND` to `ST_IDLE` ("release") on the clear pulse.
- Otherwise each state stays where it is ("hold").

Top module: `snd_irq_monitor`

## Requirements
- R1: With `irq_en`=1 and `win_mode`=1, a valid sample strictly below `thr_lo` makes `irq_oe` go to 1 after the next rising clock edge.
- R2: With `irq_en`=1 and `win_mode`=1, a valid sample strictly above `thr_hi` makes `irq_oe` go to 1 after the next rising clock edge.
- R3: The comparisons are unsigned and strict. A sample equal to `thr_lo`, equal to `thr_hi`, or between them does not raise the interrupt.
- R4: With `irq_en`=1 and `win_mode`=0, a `fill_cnt` of 90 or more raises the interrupt after the next edge. A value of 89 or less does not.
- R5: A raised interrupt stays pending whatever the later samples are, until `clr_irq` is high at a rising edge. After that edge, `irq_oe` is 0.
- R6: In fill mode, a clear while `fill_cnt` is still 90 or more drops `irq_oe` for one cycle, and then the interrupt is raised again. A clear after `fill_cnt` has fallen below 90 keeps it idle.
- R7: While `irq_en`=0, no sample and no fill count can raise the interrupt, and `irq_oe` stays 0.
- R8: `irq_do` is always 0. `irq_oe` is 1 exactly while an interrupt is pending and `irq_en`=1. Dropping `irq_en` masks a pending interrupt without discarding it.
- R9: `mm_min` and `mm_max` follow the smallest and the largest valid sample since the last clear. Both update one edge after the sample.
- R10: After reset or a clear, both outputs read 0 until a sample arrives. The first valid sample then loads both `mm_min` and `mm_max`.
- R11: `clr_mm` high at an edge sets both outputs to 0. If a valid sample arrives in the same cycle, the clear wins and the sample is dropped.
- R12: While `smp_vld`=0, `smp_lvl` has no effect on the interrupt or on `mm_min`/`mm_max`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_lvl | input | 8 | Sample level, unsigned |
| thr_lo | input | 8 | Low threshold for window mode |
| thr_hi | input | 8 | High threshold for window mode |
| win_mode | input | 1 | 1 selects window mode, 0 selects fill mode |
| irq_en | input | 1 | Interrupt enable |
| fill_cnt | input | 7 | Number of history entries currently filled |
| clr_irq | input | 1 | Pulse that clears a pending interrupt |
| clr_mm | input | 1 | Pulse that clears the min/max pair |
| irq_oe | output | 1 | Pin output enable; high drives the pin |
| irq_do | output | 1 | Pin data value, tied low |
| mm_min | output | 8 | Smallest sample since the last clear |
| mm_max | output | 8 | Largest sample since the last clear |

## Verification
The assertions take `clr_irq` and `clr_mm` to be single-cycle pulses. They also assume `fill_cnt` never exceeds the history depth of 100. The no-trigger property on an equal sample relies on `thr_lo` not being above `thr_hi`. The bench meets all of these: it drives every input on the falling edge, raises each clear for exactly one cycle, keeps `fill_cnt` at 100 or below, and keeps the threshold pair at 45/85.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_state_e;

    localparam int unsigned DEF_LVL_W      = 8;
    localparam int unsigned DEF_FILL_W     = 7;
    localparam int unsigned DEF_FILL_LIMIT = 90;

endpackage

// File: rtl/snd_irq_trig.sv
module snd_irq_trig
    import snd_irq_pkg::*;
#(
    parameter int unsigned LVL_W      = DEF_LVL_W,
    parameter int unsigned FILL_W     = DEF_FILL_W,
    parameter int unsigned FILL_LIMIT = DEF_FILL_LIMIT
) (
    input  logic              smp_vld,
    input  logic [LVL_W-1:0]  smp_lvl,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic              win_mode,
    input  logic              irq_en,
    input  logic [FILL_W-1:0] fill_cnt,
    output logic              trig
);
    localparam logic [FILL_W-1:0] LIMIT_V = FILL_W'(FILL_LIMIT);

    logic below_lo;
    logic above_hi;
    logic win_hit;
    logic fill_hit;

    always_comb begin
        below_lo = smp_lvl < thr_lo;
        above_hi = smp_lvl > thr_hi;
        win_hit  = smp_vld && (below_lo || above_hi);
        fill_hit = fill_cnt >= LIMIT_V;
        trig     = irq_en && (win_mode ? win_hit : fill_hit);
    end

endmodule

// File: rtl/snd_irq_fsm.sv
module snd_irq_fsm
    import snd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    input  logic en,
    output logic pend,
    output logic oe,
    output logic dout
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig) state_d = ST_PEND;
            ST_PEND: if (clr)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == ST_PEND);
        oe   = pend && en;
        dout = 1'b0;
    end

endmodule

// File: rtl/snd_minmax_track.sv
module snd_minmax_track
    import snd_irq_pkg::*;
#(
    parameter int unsigned LVL_W = DEF_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [LVL_W-1:0] smp_lvl,
    input  logic             clr,
    output logic [LVL_W-1:0] min_q,
    output logic [LVL_W-1:0] max_q
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            min_q  <= '0;
            max_q  <= '0;
        end else if (clr) begin
            seen_q <= 1'b0;
            min_q  <= '0;
            max_q  <= '0;
        end else if (smp_vld) begin
            seen_q <= 1'b1;
            if (!seen_q) begin
                min_q <= smp_lvl;
                max_q <= smp_lvl;
            end else begin
                if (smp_lvl < min_q) min_q <= smp_lvl;
                if (smp_lvl > max_q) max_q <= smp_lvl;
            end
        end
    end

endmodule

// File: rtl/snd_irq_monitor.sv
module snd_irq_monitor
    import snd_irq_pkg::*;
#(
    parameter int unsigned LVL_W      = DEF_LVL_W,
    parameter int unsigned FILL_W     = DEF_FILL_W,
    parameter int unsigned FILL_LIMIT = DEF_FILL_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [LVL_W-1:0]  smp_lvl,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic              win_mode,
    input  logic              irq_en,
    input  logic [FILL_W-1:0] fill_cnt,
    input  logic              clr_irq,
    input  logic              clr_mm,
    output logic              irq_oe,
    output logic              irq_do,
    output logic [LVL_W-1:0]  mm_min,
    output logic [LVL_W-1:0]  mm_max
);
    logic trig;
    logic pend;

    snd_irq_trig #(
        .LVL_W      (LVL_W),
        .FILL_W     (FILL_W),
        .FILL_LIMIT (FILL_LIMIT)
    ) u_trig (
        .smp_vld  (smp_vld),
        .smp_lvl  (smp_lvl),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .win_mode (win_mode),
        .irq_en   (irq_en),
        .fill_cnt (fill_cnt),
        .trig     (trig)
    );

    snd_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .clr   (clr_irq),
        .en    (irq_en),
        .pend  (pend),
        .oe    (irq_oe),
        .dout  (irq_do)
    );

    snd_minmax_track #(
        .LVL_W (LVL_W)
    ) u_mm (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_lvl (smp_lvl),
        .clr     (clr_mm),
        .min_q   (mm_min),
        .max_q   (mm_max)
    );

endmodule

// File: rtl/snd_irq_chk.sv
module snd_irq_chk #(
    parameter int unsigned LVL_W      = 8,
    parameter int unsigned FILL_W     = 7,
    parameter int unsigned FILL_LIMIT = 90
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [LVL_W-1:0]  smp_lvl,
    input logic [LVL_W-1:0]  thr_lo,
    input logic [LVL_W-1:0]  thr_hi,
    input logic              win_mode,
    input logic              irq_en,
    input logic [FILL_W-1:0] fill_cnt,
    input logic              clr_irq,
    input logic              clr_mm,
    input logic              irq_oe,
    input logic [LVL_W-1:0]  mm_min,
    input logic [LVL_W-1:0]  mm_max,
    input logic              pend
);
    localparam logic [FILL_W-1:0] LIMIT_V = FILL_W'(FILL_LIMIT);

    a_r1_below_low_arms: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && win_mode && smp_vld && (smp_lvl < thr_lo) && !(pend && clr_irq) |=> pend);

    a_r2_above_high_arms: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && win_mode && smp_vld && (smp_lvl > thr_hi) && !(pend && clr_irq) |=> pend);

    a_r3_equal_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        win_mode && !pend && (smp_lvl == thr_lo) && (thr_lo <= thr_hi) |=> !pend);

    a_r4_fill_arms: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && !win_mode && (fill_cnt >= LIMIT_V) && !pend |=> pend);

    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr_irq |=> pend);

    a_r5_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        pend && clr_irq |=> !pend);

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_oe);

    a_r9_order: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !clr_mm |=> mm_min <= mm_max);

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mm |=> (mm_min == '0) && (mm_max == '0));

    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && !clr_mm |=> $stable(mm_min) && $stable(mm_max));

endmodule

bind snd_irq_monitor snd_irq_chk #(
    .LVL_W      (LVL_W),
    .FILL_W     (FILL_W),
    .FILL_LIMIT (FILL_LIMIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_lvl  (smp_lvl),
    .thr_lo   (thr_lo),
    .thr_hi   (thr_hi),
    .win_mode (win_mode),
    .irq_en   (irq_en),
    .fill_cnt (fill_cnt),
    .clr_irq  (clr_irq),
    .clr_mm   (clr_mm),
    .irq_oe   (irq_oe),
    .mm_min   (mm_min),
    .mm_max   (mm_max),
    .pend     (pend)
);

// File: tb/sim_snd_irq_monitor.sv
`timescale 1ns/1ps
module sim_snd_irq_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_lvl = '0;
    logic [7:0] thr_lo = 8'd45;
    logic [7:0] thr_hi = 8'd85;
    logic       win_mode = 1'b1;
    logic       irq_en = 1'b0;
    logic [6:0] fill_cnt = '0;
    logic       clr_irq = 1'b0;
    logic       clr_mm = 1'b0;
    logic       irq_oe;
    logic       irq_do;
    logic [7:0] mm_min;
    logic [7:0] mm_max;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    snd_irq_monitor u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_lvl(smp_lvl),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .win_mode(win_mode), .irq_en(irq_en),
        .fill_cnt(fill_cnt), .clr_irq(clr_irq), .clr_mm(clr_mm),
        .irq_oe(irq_oe), .irq_do(irq_do), .mm_min(mm_min), .mm_max(mm_max)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge, so one rising edge falls inside each step.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        smp_vld = 1'b0;
        clr_irq = 1'b0;
        clr_mm  = 1'b0;
    endtask

    task automatic send(input logic [7:0] v);
        smp_vld = 1'b1;
        smp_lvl = v;
        step();
        smp_vld = 1'b0;
    endtask

    task automatic pulse_clr_irq();
        clr_irq = 1'b1;
        step();
        clr_irq = 1'b0;
    endtask

    task automatic t_reset();
        step();
        step();
        rst_n = 1'b1;
        step();
        check("R10 reset min", mm_min, 0);
        check("R10 reset max", mm_max, 0);
        check("R8 reset oe", irq_oe, 0);
        check("R8 do low", irq_do, 0);
    endtask

    task automatic t_win_low();
        irq_en = 1'b1;
        win_mode = 1'b1;
        send(8'd30);
        check("R1 below low", irq_oe, 1);
        send(8'd60);
        step();
        check("R5 latched", irq_oe, 1);
        check("R8 do while pending", irq_do, 0);
        pulse_clr_irq();
        check("R5 cleared", irq_oe, 0);
    endtask

    task automatic t_win_high();
        send(8'd90);
        check("R2 above high", irq_oe, 1);
        pulse_clr_irq();
        check("R2 clear after high", irq_oe, 0);
    endtask

    task automatic t_win_equal();
        send(8'd45);
        check("R3 equal low", irq_oe, 0);
        send(8'd85);
        check("R3 equal high", irq_oe, 0);
        send(8'd60);
        check("R3 inside window", irq_oe, 0);
    endtask

    task automatic t_vld_low();
        irq_en = 1'b1;
        win_mode = 1'b1;
        clr_mm = 1'b1;
        step();
        clr_mm = 1'b0;
        send(8'd60);
        smp_vld = 1'b0;
        smp_lvl = 8'd10;
        step();
        smp_lvl = 8'd200;
        step();
        check("R12 no irq", irq_oe, 0);
        check("R12 min", mm_min, 60);
        check("R12 max", mm_max, 60);
    endtask

    task automatic t_fill();
        win_mode = 1'b0;
        fill_cnt = 7'd89;
        step();
        check("R4 at 89", irq_oe, 0);
        fill_cnt = 7'd90;
        step();
        check("R4 at 90", irq_oe, 1);
    endtask

    task automatic t_fill_clear();
        pulse_clr_irq();
        check("R6 drop", irq_oe, 0);
        step();
        check("R6 rearm", irq_oe, 1);
        fill_cnt = 7'd0;
        pulse_clr_irq();
        check("R6 emptied clear", irq_oe, 0);
        step();
        check("R6 stays idle", irq_oe, 0);
    endtask

    task automatic t_enable();
        irq_en = 1'b0;
        win_mode = 1'b1;
        send(8'd10);
        check("R7 window disabled", irq_oe, 0);
        win_mode = 1'b0;
        fill_cnt = 7'd100;
        step();
        check("R7 fill disabled", irq_oe, 0);
        fill_cnt = 7'd0;
        win_mode = 1'b1;
        irq_en = 1'b1;
        step();
        check("R7 nothing captured", irq_oe, 0);
        send(8'd200);
        check("R8 pending shown", irq_oe, 1);
        irq_en = 1'b0;
        step();
        check("R8 masked", irq_oe, 0);
        irq_en = 1'b1;
        step();
        check("R8 unmasked", irq_oe, 1);
        pulse_clr_irq();
        check("R8 clear", irq_oe, 0);
    endtask

    task automatic t_minmax();
        irq_en = 1'b0;
        clr_mm = 1'b1;
        step();
        clr_mm = 1'b0;
        check("R11 min zero", mm_min, 0);
        check("R11 max zero", mm_max, 0);
        send(8'd70);
        check("R10 first min", mm_min, 70);
        check("R10 first max", mm_max, 70);
        send(8'd40);
        send(8'd120);
        send(8'd55);
        check("R9 min", mm_min, 40);
        check("R9 max", mm_max, 120);
    endtask

    task automatic t_clr_collide();
        clr_mm = 1'b1;
        send(8'd5);
        clr_mm = 1'b0;
        check("R11 collide min", mm_min, 0);
        check("R11 collide max", mm_max, 0);
        send(8'd99);
        check("R10 reload min", mm_min, 99);
        check("R10 reload max", mm_max, 99);
    endtask

    initial begin
        idle_inputs();
        t_reset();
        t_win_low();
        t_win_high();
        t_win_equal();
        t_vld_low();
        t_fill();
        t_fill_clear();
        t_enable();
        t_minmax();
        t_clr_collide();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule